// File: doc/BRIEF.md
# Multi-Rate Sample Packing Interleaver

This block collects sample sets from five acquisition sources. Each source has its own strobe and runs at its own rate, from 1 Hz up to 1 MHz. On each strobe the block packs that source's channels into 32-bit words using a fixed layout, puts a header word in front of them, and stores the whole record in a small FIFO owned by that source. The FIFO holds complete records, not single words.

A merging stage picks among the sources that hold at least one complete record, in round-robin order. It sends the chosen record one word at a time on a single 32-bit valid/ready stream. The words of one record are never interleaved with another record. A receiver reads the header, learns the source and the word count, and decodes the payload from the known layout of that source.

If a source strobes while its FIFO is full, that sample set is dropped and a sticky overflow flag for the source is set. The sequence count still advances, so the receiver sees a gap in the sequence numbers.

Top module: `multirate_packer`

## Requirements
- R1: Every record begins with a header word. Bits [31:28] hold the source number (0 to 4), bits [27:24] hold the number of payload words that follow (8, 1, 8, 4 and 1 for sources 0 to 4), and bits [23:16] are zero.
- R2: Source 0 carries 16 signed 16-bit channels, with channel n on `s0_data[16n+15:16n]`. Its payload is 8 words. Payload word k holds channel 2k in bits [15:0] and channel 2k+1 in bits [31:16].
- R3: Source 1 sends one payload word in which line n of `s1_lines` is bit n and bits [31:4] are zero. Source 4 sends one payload word in which line n of `s4_lines` is bit n and bits [31:16] are zero.
- R4: Sources 2 and 3 carry fixed-point channels of FXW bits each, with channel n on `sX_data[FXW*n+FXW-1:FXW*n]`. Source 2 has 8 channels and source 3 has 4. Each channel takes one payload word, in channel order, sign-extended to 32 bits.
- R5: Header bits [15:0] carry the number of strobes that source has received since reset, counted before the current one. The first record of a source after reset carries 0.
- R6: The words of one record leave the block back to back, header first, and no word from another record appears between them.
- R7: When several sources have records waiting, the source served next is the first one that has a record, searching upward with wrap-around from the source served last. After reset the search starts at source 0.
- R8: If a strobe arrives while its source's FIFO already holds DEPTH records, that sample set is discarded and `ovf_flags` bit n (n = source number) goes high. The bit stays high until reset. The sequence count still advances.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. A word is consumed on each cycle in which both are high.
- R10: During and right after reset, `out_valid` and `ovf_flags` are low.
- R11: Strobes from different sources in the same cycle are all accepted, and none of them is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_stb | input | 1 | Sample strobe, source 0 |
| s0_data | input | 256 | 16 signed 16-bit channels, source 0 |
| s1_stb | input | 1 | Sample strobe, source 1 |
| s1_lines | input | 4 | Digital lines, source 1 |
| s2_stb | input | 1 | Sample strobe, source 2 |
| s2_data | input | 8*FXW | 8 fixed-point channels, source 2 |
| s3_stb | input | 1 | Sample strobe, source 3 |
| s3_data | input | 4*FXW | 4 fixed-point channels, source 3 |
| s4_stb | input | 1 | Sample strobe, source 4 |
| s4_lines | input | 16 | Digital lines, source 4 |
| out_data | output | 32 | Output stream word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| ovf_flags | output | 5 | Sticky per-source overflow flags |

## Verification
The assertions check the following on every cycle:
- the handshake hold rule;
- that the source number in each header agrees with the source the merger is serving;
- that the served source does not change partway through a record;
- that a dropped strobe always raises its overflow flag, and that the flags never fall.

Other behaviours need the bench's scenarios and its scoreboard:
- the exact packing of each source's channels;
- the sequence numbers, including the gap left by a drop;
- the round-robin order after many sources fill their FIFOs together;
- drops occurring only when a FIFO really is full.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int NSRC = 5;
  localparam int MAXW = 9;

  typedef logic [MAXW-1:0][31:0] rec_t;

  // Words per record, header included.
  function automatic int unsigned rec_len(int unsigned id);
    case (id)
      0: return 9;
      1: return 2;
      2: return 9;
      3: return 5;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] hdr_word(logic [3:0] id, logic [3:0] cnt, logic [15:0] seq);
    return {id, cnt, 8'h00, seq};
  endfunction

  function automatic logic [31:0] pair_word(logic [15:0] lo, logic [15:0] hi);
    return {hi, lo};
  endfunction

  // Result is {found, index}. Searches upward from last+1 and wraps.
  function automatic logic [3:0] rr_pick(logic [NSRC-1:0] req, logic [2:0] last);
    logic [3:0] r;
    r = '0;
    for (int off = NSRC; off >= 1; off--) begin
      int c;
      c = (int'(last) + off) % NSRC;
      if (req[c]) r = {1'b1, 3'(c)};
    end
    return r;
  endfunction
endpackage

// File: rtl/mrp_rec_fifo.sv
module mrp_rec_fifo #(
  parameter int W     = 288,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rptr];

  logic do_wr, do_rd;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/mrp_merger.sv
module mrp_merger
  import mrp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       avail,
  input  rec_t [NSRC-1:0]       heads,
  input  logic                  out_ready,
  output logic [31:0]           out_data,
  output logic                  out_valid,
  output logic [NSRC-1:0]       pop,
  output logic [2:0]            cur_src,
  output logic                  first_beat,
  output logic                  last_beat
);
  logic       busy;
  logic [2:0] src, last_src;
  logic [3:0] idx;
  logic [3:0] pick;
  rec_t       cur_rec;

  assign pick       = rr_pick(avail, last_src);
  assign out_valid  = busy;
  assign cur_src    = src;
  assign first_beat = busy && (idx == '0);
  assign last_beat  = busy && (idx == 4'(rec_len(int'(src)) - 1));

  always_comb begin
    cur_rec = '0;
    for (int i = 0; i < NSRC; i++)
      if (src == 3'(i)) cur_rec = heads[i];
    out_data = '0;
    for (int k = 0; k < MAXW; k++)
      if (idx == 4'(k)) out_data = cur_rec[k];
    for (int i = 0; i < NSRC; i++)
      pop[i] = busy && out_ready && last_beat && (src == 3'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      src      <= '0;
      idx      <= '0;
      last_src <= 3'(NSRC-1);
    end else if (!busy) begin
      if (pick[3]) begin
        busy <= 1'b1;
        src  <= pick[2:0];
        idx  <= '0;
      end
    end else if (out_ready) begin
      if (last_beat) begin
        busy     <= 1'b0;
        last_src <= src;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/multirate_packer.sv
module multirate_packer
  import mrp_pkg::*;
#(
  parameter int FXW   = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_stb,
  input  logic [255:0]     s0_data,
  input  logic             s1_stb,
  input  logic [3:0]       s1_lines,
  input  logic             s2_stb,
  input  logic [8*FXW-1:0] s2_data,
  input  logic             s3_stb,
  input  logic [4*FXW-1:0] s3_data,
  input  logic             s4_stb,
  input  logic [15:0]      s4_lines,
  output logic [31:0]      out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NSRC-1:0]  ovf_flags
);
  localparam int RW = $bits(rec_t);

  logic [NSRC-1:0]       stb, push, drop, full, empty, pop;
  logic [NSRC-1:0][15:0] seq;
  rec_t [NSRC-1:0]       rec_in, heads;
  logic [2:0]            cur_src;
  logic                  first_beat, last_beat;

  assign stb = {s4_stb, s3_stb, s2_stb, s1_stb, s0_stb};

  always_comb begin
    rec_in = '0;
    for (int k = 0; k < 8; k++)
      rec_in[0][k+1] = pair_word(s0_data[32*k +: 16], s0_data[32*k+16 +: 16]);
    rec_in[1][1] = {28'h0, s1_lines};
    for (int n = 0; n < 8; n++)
      rec_in[2][n+1] = 32'($signed(s2_data[n*FXW +: FXW]));
    for (int n = 0; n < 4; n++)
      rec_in[3][n+1] = 32'($signed(s3_data[n*FXW +: FXW]));
    rec_in[4][1] = {16'h0, s4_lines};
    for (int g = 0; g < NSRC; g++)
      rec_in[g][0] = hdr_word(4'(g), 4'(rec_len(g) - 1), seq[g]);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign push[g] = stb[g] && !full[g];
    assign drop[g] = stb[g] && full[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq[g]       <= '0;
        ovf_flags[g] <= 1'b0;
      end else begin
        if (stb[g])  seq[g]       <= seq[g] + 16'd1;
        if (drop[g]) ovf_flags[g] <= 1'b1;
      end
    end

    mrp_rec_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push[g]),
      .wr_data (rec_in[g]),
      .rd_en   (pop[g]),
      .rd_data (heads[g]),
      .full    (full[g]),
      .empty   (empty[g])
    );
  end

  mrp_merger u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .avail      (~empty),
    .heads      (heads),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .pop        (pop),
    .cur_src    (cur_src),
    .first_beat (first_beat),
    .last_beat  (last_beat)
  );
endmodule

// File: rtl/mrp_chk.sv
module mrp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] out_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [4:0]  ovf_flags,
  input logic [4:0]  drop,
  input logic [2:0]  cur_src,
  input logic        first_beat,
  input logic        last_beat
);
  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  header_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && first_beat |-> (out_data[31:28] == {1'b0, cur_src}) && (out_data[31:28] < 4'd5));

  // R6
  no_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && last_beat) |=> out_valid && $stable(cur_src));

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop != 5'b0) |=> ((ovf_flags & $past(drop)) == $past(drop)));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags & $past(ovf_flags)) == $past(ovf_flags));
endmodule

bind multirate_packer mrp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .ovf_flags  (ovf_flags),
  .drop       (drop),
  .cur_src    (cur_src),
  .first_beat (first_beat),
  .last_beat  (last_beat)
);

// File: tb/sim_multirate_packer.sv
module sim_multirate_packer;
  localparam int FXW   = 24;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_stb = 0, s1_stb = 0, s2_stb = 0, s3_stb = 0, s4_stb = 0;
  logic [255:0]     s0_data = '0;
  logic [3:0]       s1_lines = '0;
  logic [8*FXW-1:0] s2_data = '0;
  logic [4*FXW-1:0] s3_data = '0;
  logic [15:0]      s4_lines = '0;
  logic [31:0]      out_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [4:0]       ovf_flags;

  always #4 clk = ~clk;

  multirate_packer #(.FXW(FXW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s0_stb(s0_stb), .s0_data(s0_data),
    .s1_stb(s1_stb), .s1_lines(s1_lines),
    .s2_stb(s2_stb), .s2_data(s2_data),
    .s3_stb(s3_stb), .s3_data(s3_data),
    .s4_stb(s4_stb), .s4_lines(s4_lines),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .ovf_flags(ovf_flags)
  );

  typedef struct {
    int                id;
    int                len;
    logic [8:0][31:0]  w;
  } exp_t;

  exp_t expq[$];
  int   order_q[$];
  int   seqm [5];
  int   n_chk = 0, n_fail = 0;
  int   ready_mode = 0;
  int   last_rx = 4;
  bit   done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string src_req(int id);
    case (id)
      0: return "R2";
      2, 3: return "R4";
      default: return "R3";
    endcase
  endfunction

  // Driver: sets one source's bus and strobe, and pushes the expected record.
  task automatic arm(int id, bit dropped);
    exp_t e;
    int   cnt;
    cnt  = (id == 0 || id == 2) ? 8 : (id == 3) ? 4 : 1;
    e.id = id;
    e.len = cnt + 1;
    e.w = '0;
    e.w[0] = {4'(id), 4'(cnt), 8'h00, 16'(seqm[id])};
    case (id)
      0: begin
        for (int k = 0; k < 8; k++) s0_data[32*k +: 32] = $urandom;
        for (int k = 0; k < 8; k++)
          e.w[k+1] = {s0_data[16*(2*k+1) +: 16], s0_data[16*(2*k) +: 16]};
        s0_stb = 1;
      end
      1: begin
        s1_lines = 4'($urandom);
        e.w[1] = {28'h0, s1_lines};
        s1_stb = 1;
      end
      2: begin
        for (int n = 0; n < 8; n++) begin
          s2_data[n*FXW +: FXW] = FXW'($urandom);
          e.w[n+1] = {{(32-FXW){s2_data[n*FXW+FXW-1]}}, s2_data[n*FXW +: FXW]};
        end
        s2_stb = 1;
      end
      3: begin
        for (int n = 0; n < 4; n++) begin
          s3_data[n*FXW +: FXW] = FXW'($urandom);
          e.w[n+1] = {{(32-FXW){s3_data[n*FXW+FXW-1]}}, s3_data[n*FXW +: FXW]};
        end
        s3_stb = 1;
      end
      default: begin
        s4_lines = 16'($urandom);
        e.w[1] = {16'h0, s4_lines};
        s4_stb = 1;
      end
    endcase
    seqm[id]++;
    if (!dropped) expq.push_back(e);
  endtask

  task automatic fire();
    @(posedge clk); #1;
    s0_stb = 0; s1_stb = 0; s2_stb = 0; s3_stb = 0; s4_stb = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    while (expq.size() != 0 || in_rec) idle(1);
    idle(3);
  endtask

  // Drives out_ready according to the current mode.
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: out_ready = 1'b0;
        1: out_ready = 1'b1;
        default: out_ready = 1'($urandom);
      endcase
    end
  end

  // Monitor and scoreboard.
  bit          in_rec = 0;
  exp_t        cur;
  int          pos = 0;
  bit          stalled = 0;
  logic [31:0] held = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) chk(out_valid && out_data == held, "R9", out_data, held);
      if (out_valid && out_ready) begin
        if (!in_rec) begin
          int id;
          int hit;
          id  = int'(out_data[31:28]);
          hit = -1;
          for (int i = 0; i < expq.size(); i++)
            if (hit < 0 && expq[i].id == id) hit = i;
          chk(hit >= 0, "R1 unexpected header", out_data, 32'h0);
          if (hit >= 0) begin
            cur = expq[hit];
            expq.delete(hit);
            chk(out_data == cur.w[0], "R1,R5 header", out_data, cur.w[0]);
            in_rec = 1;
            pos = 1;
          end
        end else begin
          chk(out_data == cur.w[pos], src_req(cur.id), out_data, cur.w[pos]);
          pos++;
          if (pos == cur.len) begin
            in_rec = 0;
            order_q.push_back(cur.id);
            last_rx = cur.id;
          end
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int exp_order[$];
    int pend [5];
    int curp;
    for (int i = 0; i < 5; i++) seqm[i] = 0;

    // R10: reset state
    idle(4);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid", 32'(out_valid), 32'h0);
    chk(ovf_flags == 5'b0, "R10 flags", 32'(ovf_flags), 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid after release", 32'(out_valid), 32'h0);
    @(posedge clk); #1;

    // R2 R3 R4 R5: one record per source with ready held high
    ready_mode = 1;
    for (int s = 0; s < 5; s++) begin
      arm(s, 0); fire(); idle(12);
    end
    drain();

    // R9 R6: random backpressure with spaced random strobes
    ready_mode = 2;
    for (int i = 0; i < 30; i++) begin
      arm(int'($urandom % 5), 0); fire(); idle(40);
    end
    ready_mode = 1;
    drain();
    chk(ovf_flags == 5'b0, "R8 no spurious drop", 32'(ovf_flags), 32'h0);

    // R11 R7: all sources at once, then source 0 again, while stalled
    ready_mode = 0;
    idle(2);
    order_q.delete();
    for (int s = 0; s < 5; s++) arm(s, 0);
    fire();
    arm(0, 0); fire();
    for (int s = 0; s < 5; s++) pend[s] = 1;
    pend[0] = 2;
    curp = last_rx;
    for (int n = 0; n < 6; n++) begin
      for (int off = 1; off <= 5; off++) begin
        int c;
        c = (curp + off) % 5;
        if (pend[c] > 0) begin
          pend[c]--;
          exp_order.push_back(c);
          curp = c;
          break;
        end
      end
    end
    idle(3);
    ready_mode = 1;
    drain();
    chk(order_q.size() == 6, "R11 record count", 32'(order_q.size()), 32'd6);
    for (int i = 0; i < 6 && i < order_q.size(); i++)
      chk(order_q[i] == exp_order[i], "R7 order", 32'(order_q[i]), 32'(exp_order[i]));

    // R8: overflow of source 1 while the output is stalled
    ready_mode = 0;
    idle(2);
    for (int i = 0; i < DEPTH; i++) begin arm(1, 0); fire(); end
    arm(1, 1); fire();
    @(negedge clk);
    chk(ovf_flags == 5'b00010, "R8 flag set", 32'(ovf_flags), 32'h2);
    @(posedge clk); #1;
    ready_mode = 1;
    drain();
    arm(1, 0); fire();
    drain();
    @(negedge clk);
    chk(ovf_flags == 5'b00010, "R8 flag sticky", 32'(ovf_flags), 32'h2);
    chk(expq.size() == 0, "R5 all records seen", 32'(expq.size()), 32'h0);

    done = 1;
    summary();
  end
endmodule